// File: doc/BRIEF.md
# Interrupt Presentation and Acknowledge Unit

This unit sits between the interrupt source controller and one processor core. Source notifications arrive one at a time on a valid/ready pair. Each notification carries a source number and a priority. The unit holds at most one pending interrupt and summarises it on a single level output to the core. A notification is taken only while its priority value is lower than the current processor priority. Lower values are more favoured.

Software sees two 32-bit registers:
- The request register, at address 0. Bits 31..24 hold the current processor priority. Bits 23..0 hold the pending source number, which is 0 when nothing is pending.
- The inter-processor request register, at address 1, in bits 7..0.

Reading the request register acknowledges the pending interrupt. Writing the request register ends the interrupt by restoring the priority. Software can post an interrupt to the core by writing a favourable value into the inter-processor request register.

Top module: `intr_presenter`

## Requirements
- R1: After reset the current priority is 0x00, the inter-processor request register is 0xFF, the pending source number is 0, `irq_out` is low and `src_ready` is high.
- R2: When a notification handshakes while nothing is pending and its priority is lower than the current priority, in the next cycle `irq_out` is high and the pending source number equals the notified number. Source numbers are nonzero.
- R3: A notification that handshakes with a priority equal to or above the current priority is dropped. It leaves `irq_out` low and the pending number 0.
- R4: While an interrupt is pending, `src_ready` is low. The pending number and priority then hold until an acknowledge.
- R5: A read of address 0 returns the current priority in bits 31..24 and the pending number in bits 23..0 in the following cycle. If an interrupt was pending, the same clock edge sets the current priority to that interrupt's priority, clears the pending number, drops `irq_out` and raises `src_ready`.
- R6: A read of address 0 with nothing pending returns a source number of 0 and leaves the current priority unchanged.
- R7: A write to address 0 loads the current priority from bits 31..24 of the written data. Notifications compare against the new value from the next cycle onward. A read of address 0 in the same cycle takes precedence over the write, and the write is then ignored.
- R8: A write to address 1 loads bits 7..0 into the inter-processor request register. A read of address 1 returns that register in bits 7..0 with zeros above it.
- R9: While nothing is pending and the inter-processor request value is lower than the current priority, the unit presents reserved source number 2, with the inter-processor value as its priority. If a source notification qualifies in the same cycle, the lower priority value wins, and a tie goes to source 2.
- R10: `irq_out` is high exactly when the pending source number is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Notification offered by the source controller |
| src_num | input | 24 | Source number of the notification, nonzero |
| src_prio | input | 8 | Priority of the notification, lower is more favoured |
| src_ready | output | 1 | Unit can take a notification |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the request register, 1 the inter-processor register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_out | output | 1 | Single interrupt line to the core |

## Verification
A source notification can be taken in the same cycle that software acknowledges or ends an interrupt. The bench provokes this by offering a notification on the very cycle of an end-of-interrupt write. It expects the notification to be compared against the old priority and dropped, and then taken when it is offered again one cycle later. The bench also lines up an inter-processor post with a source notification of equal priority, and expects source 2 to be presented. A long random phase drives reads, writes and notifications together, and compares every output on every clock against a behavioural model.

// File: rtl/intr_presenter.sv
module intr_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      src_valid,
  input  logic [SRC_W-1:0]          src_num,
  input  logic [PRIO_W-1:0]         src_prio,
  output logic                      src_ready,
  input  logic                      reg_rd,
  input  logic                      reg_wr,
  input  logic                      reg_addr,
  input  logic [SRC_W+PRIO_W-1:0]   reg_wdata,
  output logic [SRC_W+PRIO_W-1:0]   reg_rdata,
  output logic                      irq_out
);
  localparam int DATA_W = SRC_W + PRIO_W;
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cppr, mfrr, pend_prio;
  logic [SRC_W-1:0]  xisr;

  wire idle     = (xisr == '0);
  wire rd_x     = reg_rd & ~reg_addr;
  wire rd_m     = reg_rd &  reg_addr;
  wire wr_x     = reg_wr & ~reg_addr & ~rd_x;
  wire wr_m     = reg_wr &  reg_addr;
  wire src_ok   = src_valid & idle & (src_prio < cppr);
  wire ipi_ok   = idle & (mfrr < cppr);
  wire ipi_take = ipi_ok & (~src_ok | (mfrr <= src_prio));
  wire src_take = src_ok & ~ipi_take;

  assign src_ready = idle;
  assign irq_out   = ~idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr      <= '0;
      mfrr      <= '1;
      pend_prio <= '1;
      xisr      <= '0;
      reg_rdata <= '0;
    end else begin
      if (wr_m) mfrr <= reg_wdata[PRIO_W-1:0];
      if (wr_x) cppr <= reg_wdata[DATA_W-1:SRC_W];
      if (rd_x) begin
        reg_rdata <= {cppr, xisr};
        if (!idle) begin
          cppr <= pend_prio;
          xisr <= '0;
        end
      end else if (rd_m) begin
        reg_rdata <= {{SRC_W{1'b0}}, mfrr};
      end
      if (ipi_take) begin
        xisr      <= IPI_NUM;
        pend_prio <= mfrr;
      end else if (src_take) begin
        xisr      <= src_num;
        pend_prio <= src_prio;
      end
    end
  end

  // R2
  src_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |=> irq_out && xisr == $past(src_num));
  // R3
  src_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready && src_prio >= cppr && !ipi_take) |=> !irq_out);
  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !rd_x) |=> $stable(xisr) && $stable(pend_prio) && !src_ready);
  // R5
  ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_x && !idle) |=> !irq_out && cppr == $past(pend_prio)
                         && reg_rdata == $past({cppr, xisr}));
  // R7
  eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_x |=> cppr == $past(reg_wdata[DATA_W-1:SRC_W]));
  // R8
  mfrr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_m |=> mfrr == $past(reg_wdata[PRIO_W-1:0]));
  // R9
  ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_take |=> irq_out && xisr == IPI_NUM);
endmodule

// File: tb/intr_presenter_tb.sv
module intr_presenter_tb;
  logic clk = 0, rst_n = 0;
  logic src_valid = 0, reg_rd = 0, reg_wr = 0, reg_addr = 0;
  logic [23:0] src_num = 0;
  logic [7:0]  src_prio = 0;
  logic [31:0] reg_wdata = 0;
  logic        src_ready, irq_out;
  logic [31:0] reg_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intr_presenter u_dut (.clk, .rst_n, .src_valid, .src_num, .src_prio, .src_ready,
    .reg_rd, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq_out);

  // behavioural reference
  logic [7:0]  m_cppr, m_mfrr, m_pp;
  logic [23:0] m_x;
  logic [31:0] m_rd;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cppr = 0; m_mfrr = 8'hFF; m_pp = 8'hFF; m_x = 0; m_rd = 0;
    end else begin
      automatic bit busy = (m_x != 0);
      automatic logic [7:0] old_c = m_cppr, old_m = m_mfrr;
      automatic bit s = src_valid && !busy && (src_prio < old_c);
      automatic bit i = !busy && (old_m < old_c);
      if (reg_rd && reg_addr) m_rd = {24'h0, old_m};
      if (reg_wr && reg_addr) m_mfrr = reg_wdata[7:0];
      if (reg_rd && !reg_addr) begin
        m_rd = {old_c, m_x};
        if (busy) begin m_cppr = m_pp; m_x = 0; end
      end else if (reg_wr && !reg_addr) m_cppr = reg_wdata[31:24];
      if (i && (!s || old_m <= src_prio)) begin m_x = 24'd2; m_pp = old_m; end
      else if (s) begin m_x = src_num; m_pp = src_prio; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R10 irq_out vs model", {31'h0, irq_out}, {31'h0, m_x != 0});
      chk("R4 src_ready vs model", {31'h0, src_ready}, {31'h0, m_x == 0});
      chk("R5 rdata vs model", reg_rdata, m_rd);
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic idle_in();
    src_valid = 0; reg_rd = 0; reg_wr = 0;
  endtask
  task automatic op(bit rd, bit wr, bit a, logic [31:0] d);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
  endtask
  task automatic notify(logic [23:0] n, logic [7:0] p);
    src_valid = 1; src_num = n; src_prio = p;
  endtask

  initial begin
    #1_000_000;
    errors++; $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    chk("R1 ready after reset", {31'h0, src_ready}, 32'h1);
    chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
    op(1, 0, 0, 0); cyc(); idle_in();
    chk("R1 R6 xirr after reset", reg_rdata, 32'h0);
    op(1, 0, 1, 0); cyc(); idle_in();
    chk("R1 R8 mfrr reset", reg_rdata, 32'h0000_00FF);
    notify(24'h33, 8'h05); cyc(); idle_in(); cyc();
    chk("R3 masked by cppr 0", {31'h0, irq_out}, 32'h0);
    // end-of-interrupt write and notification in the same cycle
    op(0, 1, 0, 32'hFF00_0000); notify(24'h33, 8'h05); cyc(); idle_in();
    chk("R7 old cppr used same cycle", {31'h0, irq_out}, 32'h0);
    notify(24'h33, 8'h05); cyc(); idle_in();
    chk("R2 accepted next cycle", {31'h0, irq_out}, 32'h1);
    chk("R4 ready low while pending", {31'h0, src_ready}, 32'h0);
    notify(24'h44, 8'h01); cyc(); idle_in();
    op(1, 0, 0, 0); cyc(); idle_in();
    chk("R5 ack read data", reg_rdata, 32'hFF00_0033);
    chk("R5 irq dropped", {31'h0, irq_out}, 32'h0);
    chk("R5 ready back", {31'h0, src_ready}, 32'h1);
    op(1, 0, 0, 0); cyc(); idle_in();
    chk("R6 idle read cppr raised", reg_rdata, 32'h0500_0000);
    op(0, 1, 0, 32'hFF00_0000); cyc();
    op(0, 1, 1, 32'h0000_0003); cyc(); idle_in(); cyc();
    chk("R9 ipi raises irq", {31'h0, irq_out}, 32'h1);
    op(1, 0, 0, 0); cyc(); idle_in();
    chk("R9 ipi source 2", reg_rdata, 32'hFF00_0002);
    op(0, 1, 1, 32'h0000_00FF); cyc();
    op(0, 1, 0, 32'hFF00_0000); cyc();
    op(0, 1, 1, 32'h0000_0004); cyc(); idle_in();
    notify(24'h77, 8'h04); cyc(); idle_in();
    op(1, 0, 0, 0); cyc(); idle_in();
    chk("R9 tie goes to ipi", reg_rdata, 32'hFF00_0002);
    op(0, 1, 1, 32'h0000_00FF); cyc(); idle_in();
    for (int k = 0; k < 4000; k++) begin
      automatic int r = $urandom_range(0, 9);
      idle_in();
      src_valid = $urandom_range(0, 1);
      src_num = 24'($urandom_range(1, 500));
      src_prio = 8'($urandom_range(0, 15));
      if (r < 3) op(1, 0, r[0], 0);
      else if (r == 3) op(0, 1, 0, {8'($urandom_range(0, 16)), 24'h0});
      else if (r == 4) op(0, 1, 1, 32'($urandom_range(0, 20)));
      else if (r == 5) op(1, 1, 1, 32'($urandom_range(0, 20)));
      cyc();
    end
    idle_in(); cyc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule